// File: doc/BRIEF.md
# SDRAM Command Decoder and Two-Bank State Tracker

This block sits beside a synchronous DRAM interface and watches its control pins. It registers chip select, the row strobe, the column strobe, write enable, clock enable and the 12-bit address on every rising clock edge. One cycle later it reports which command was seen, as a one-hot vector. It also keeps a model of two banks: whether each is open, and which row each one holds. It captures the mode word and follows auto-precharge and precharge requests. Commands that break bank rules are flagged and are not carried out. The block has no data path and no memory array.

Each bank runs its own state machine, which has three states. From `BK_IDLE`, a legal activate moves the bank to `BK_ACTIVE` and latches the row. From `BK_ACTIVE`, a precharge that covers the bank returns it to `BK_IDLE`. A read or write with the auto-precharge bit set moves it to `BK_CLOSING` and loads a countdown equal to the burst length. A read or write without that bit leaves the bank in `BK_ACTIVE`. From `BK_CLOSING`, the bank returns to `BK_IDLE` on a covering precharge or when the countdown expires. A bank in `BK_ACTIVE` or `BK_CLOSING` is reported as open.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is held and before the first command is decoded, `cmd_oh` is zero, `proto_err` is 0, both banks are closed, both rows are zero and `mode_word` is 12'h020.
- R2: Pins sampled at clock edge N appear at edge N+1 as exactly one bit of `cmd_oh`. With chip select low, the {ras_n,cas_n,we_n} codes map as follows. 011 is activate (bit 2), 101 is read (bit 3), 100 is write (bit 4), 010 is precharge (bit 5), 110 is burst stop (bit 6), 000 is mode set (bit 7), 111 is no-op (bit 1) and 001 is refresh (bit 8).
- R3: If chip select is high or clock enable is low at the sampling edge, the result is deselect (bit 0). Nothing changes, except that a running auto-precharge countdown keeps going.
- R4: A legal activate opens the bank named by address bit 11 (0 selects bank 0, 1 selects bank 1). It also latches address bits 10:0 as that bank's row.
- R5: A read or write to an open bank with address bit 10 low leaves the bank open. A read or write to a bank that is idle or closing is a violation.
- R6: A legal read or write with address bit 10 high keeps the bank open for B cycles and then closes it. B is 1, 2, 4 or 8 for mode bits 2:0 = 0, 1, 2, 3, and 1 for any other code.
- R7: A precharge with address bit 10 high closes both banks, whatever bit 11 holds. With bit 10 low it closes only the bank named by bit 11. A precharge to an idle bank is harmless and is not a violation.
- R8: An activate to a bank that is open or closing is a violation. The bank's row and state do not change.
- R9: A mode set stores all 12 address bits into `mode_word`. This happens only when both banks are idle and bits 6:4 are 010 (latency 2) or 011 (latency 3). In any other case it is a violation and the word is kept.
- R10: A refresh with both banks idle is legal and changes nothing. A refresh with any bank open is a violation.
- R11: `proto_err` is high for exactly the cycle in which `cmd_oh` shows the offending command. It can only accompany activate, read, write, mode set or refresh.
- R12: No-op and burst stop change no bank state, no row and no mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin; low turns the sampled slot into deselect |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address; bit 11 selects the bank, bit 10 carries the precharge flag |
| cmd_oh | output | 9 | One-hot decoded command, one cycle after sampling |
| bank_open | output | 2 | Per-bank open flag |
| bank_row | output | 22 | Latched rows; bank b in bits [b*11 +: 11] |
| mode_word | output | 12 | Captured mode word |
| proto_err | output | 1 | One-cycle violation pulse |

## Verification
A bank state machine that is in the wrong state shows up at the next legal or illegal access to that bank. It gives a wrong `bank_open` bit, or a `proto_err` pulse that is missing or should not be there, one cycle after the pins were sampled. A countdown that is off by one shows as a bank that closes one cycle early or late, so `bank_open` is compared in every cycle during auto-precharge. Row or mode corruption is visible at once on `bank_row` or `mode_word`. The bench therefore compares all outputs on every clock, in sweeps over all pin codes and in directed bank sequences.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int CMD_N = 9;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_BST   = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_REF   = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_ACTIVE  = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
    } pins_t;

    localparam logic [2:0] LAT_CODE_2 = 3'b010;
    localparam logic [2:0] LAT_CODE_3 = 3'b011;

    // Burst length in cycles for the 3-bit length code; other codes count as one beat.
    function automatic int burst_cycles(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  pins_t pins,
    output cmd_e  cmd
);

    always_comb begin
        if (!pins.cke || pins.cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({pins.ras_n, pins.cas_n, pins.we_n})
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b010: cmd = CMD_PRE;
                3'b110: cmd = CMD_BST;
                3'b000: cmd = CMD_MRS;
                3'b001: cmd = CMD_REF;
                3'b111: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rw_go,
    input  logic             ap_req,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CNT_W-1:0] bl_in,
    output bank_st_e         state_o,
    output logic [ROW_W-1:0] row_o
);

    bank_st_e         st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [ROW_W-1:0] row_q, row_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            row_q <= row_n;
        end
    end

    // Next state and outputs
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        row_n = row_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_go) begin
                    st_n  = BK_ACTIVE;
                    row_n = row_in;
                end
            end
            BK_ACTIVE: begin
                if (pre_go) begin
                    st_n = BK_IDLE;
                end else if (rw_go && ap_req) begin
                    st_n  = BK_CLOSING;
                    cnt_n = bl_in;
                end
            end
            BK_CLOSING: begin
                if (pre_go || cnt_q <= CNT_W'(1)) begin
                    st_n  = BK_IDLE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                st_n  = BK_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    assign state_o = st_q;
    assign row_o   = row_q;

endmodule

// File: rtl/sdcmd_mode.sv
module sdcmd_mode #(
    parameter int             MODE_W = 12,
    parameter logic [11:0]    RST_VAL = 12'h020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] din,
    output logic [MODE_W-1:0] mode_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_W'(RST_VAL);
        end else if (load) begin
            mode_o <= din;
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          ROW_W    = 11,
    parameter int          BANKS    = 2,
    parameter int          MAX_BL   = 8,
    parameter logic [11:0] MODE_RST = 12'h020
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [ADDR_W-1:0]      addr,
    output logic [CMD_N-1:0]       cmd_oh,
    output logic [BANKS-1:0]       bank_open,
    output logic [BANKS*ROW_W-1:0] bank_row,
    output logic [ADDR_W-1:0]      mode_word,
    output logic                   proto_err
);

    localparam int SEL_W   = $clog2(BANKS);
    localparam int SEL_BIT = ADDR_W - 1;
    localparam int AP_BIT  = ROW_W - 1;
    localparam int CNT_W   = $clog2(MAX_BL + 1);
    localparam int LAT_LSB = 4;

    // Input capture stage
    pins_t             pins_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b0};
            addr_q <= '0;
        end else begin
            pins_q <= '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n, cke: cke};
            addr_q <= addr;
        end
    end

    cmd_e cmd;

    sdcmd_decode u_decode (
        .pins (pins_q),
        .cmd  (cmd)
    );

    logic [SEL_W-1:0] sel;
    logic             ap;
    logic             lat_ok;
    logic [CNT_W-1:0] bl_cnt;

    assign sel    = addr_q[SEL_BIT -: SEL_W];
    assign ap     = addr_q[AP_BIT];
    assign lat_ok = (addr_q[LAT_LSB +: 3] == LAT_CODE_2) || (addr_q[LAT_LSB +: 3] == LAT_CODE_3);
    assign bl_cnt = CNT_W'(burst_cycles(mode_word[2:0]));

    bank_st_e         st    [BANKS];
    logic [ROW_W-1:0] row   [BANKS];
    logic [BANKS-1:0] idle_v, act_v;
    logic [BANKS-1:0] act_go, rw_go, pre_go;
    logic             all_idle;
    logic             viol;

    assign all_idle = &idle_v;

    // Legality of the decoded command against the bank states
    always_comb begin
        case (cmd)
            CMD_ACT:        viol = !idle_v[sel];
            CMD_RD, CMD_WR: viol = !act_v[sel];
            CMD_MRS:        viol = !all_idle || !lat_ok;
            CMD_REF:        viol = !all_idle;
            default:        viol = 1'b0;
        endcase
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign idle_v[b] = (st[b] == BK_IDLE);
        assign act_v[b]  = (st[b] == BK_ACTIVE);
        assign act_go[b] = (cmd == CMD_ACT) && !viol && (sel == SEL_W'(b));
        assign rw_go[b]  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !viol && (sel == SEL_W'(b));
        assign pre_go[b] = (cmd == CMD_PRE) && (ap || (sel == SEL_W'(b)));

        sdcmd_bank #(
            .ROW_W (ROW_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_go  (act_go[b]),
            .rw_go   (rw_go[b]),
            .ap_req  (ap),
            .pre_go  (pre_go[b]),
            .row_in  (addr_q[ROW_W-1:0]),
            .bl_in   (bl_cnt),
            .state_o (st[b]),
            .row_o   (row[b])
        );

        assign bank_open[b]                 = !idle_v[b];
        assign bank_row[b*ROW_W +: ROW_W]   = row[b];
    end

    sdcmd_mode #(
        .MODE_W  (ADDR_W),
        .RST_VAL (MODE_RST)
    ) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   ((cmd == CMD_MRS) && !viol),
        .din    (addr_q),
        .mode_o (mode_word)
    );

    // Report stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_oh    <= '0;
            proto_err <= 1'b0;
        end else begin
            cmd_oh    <= {{(CMD_N-1){1'b0}}, 1'b1} << cmd;
            proto_err <= viol;
        end
    end

endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk #(
    parameter int MODE_W = 12,
    parameter int ROW_W  = 11,
    parameter int BANKS  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel_pin,
    input logic [8:0]             cmd_oh,
    input logic [BANKS-1:0]       bank_open,
    input logic [BANKS*ROW_W-1:0] bank_row,
    input logic [MODE_W-1:0]      mode_word,
    input logic                   proto_err
);

    localparam logic [8:0] ERR_CMDS = 9'h19C;

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_oh))
        else $error("cmd_oh not one-hot");

    p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oh[0] |-> !proto_err && $stable(bank_row) && $stable(mode_word))
        else $error("deselect changed state");

    p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oh[2] && !proto_err |-> bank_open[$past(sel_pin, 2)])
        else $error("activate did not open bank");

    p_row_only_on_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_row) |-> cmd_oh[2] && !proto_err)
        else $error("row changed without legal activate");

    p_mode_only_on_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_word) |-> cmd_oh[7] && !proto_err)
        else $error("mode changed without legal mode set");

    p_ref_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oh[8] && !proto_err |-> bank_open == '0)
        else $error("legal refresh with a bank open");

    p_err_cmds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (cmd_oh & ERR_CMDS) != '0)
        else $error("violation on a command that cannot violate");

endmodule

bind sdram_cmd_tracker sdcmd_chk #(
    .MODE_W (ADDR_W),
    .ROW_W  (ROW_W),
    .BANKS  (BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_pin   (addr[ADDR_W-1]),
    .cmd_oh    (cmd_oh),
    .bank_open (bank_open),
    .bank_row  (bank_row),
    .mode_word (mode_word),
    .proto_err (proto_err)
);

// File: tb/tb_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_tracker;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [8:0]  cmd_oh;
    logic [1:0]  bank_open;
    logic [21:0] bank_row;
    logic [11:0] mode_word;
    logic        proto_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    sdram_cmd_tracker dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .cmd_oh(cmd_oh),
        .bank_open(bank_open), .bank_row(bank_row), .mode_word(mode_word),
        .proto_err(proto_err)
    );

    // Bench model, built from the requirements
    logic [4:0]  m_pins = 5'b11110;   // {cs_n,ras_n,cas_n,we_n,cke}
    logic [11:0] m_addr = '0;
    int          m_st  [2] = '{0, 0}; // 0 idle, 1 active, 2 closing
    int          m_cnt [2] = '{0, 0};
    logic [10:0] m_row [2] = '{11'd0, 11'd0};
    logic [11:0] m_mode = 12'h020;
    logic [8:0]  e_cmd = '0;
    logic        e_err = 1'b0;

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic model_edge();
        int c, sel, bl;
        logic ap, all_idle, lat_ok, err;
        if (!m_pins[0] || m_pins[4]) c = 0;
        else case (m_pins[3:1])
            3'b011: c = 2; 3'b101: c = 3; 3'b100: c = 4; 3'b010: c = 5;
            3'b110: c = 6; 3'b000: c = 7; 3'b001: c = 8; default: c = 1;
        endcase
        sel = int'(m_addr[11]);
        ap = m_addr[10];
        all_idle = (m_st[0] == 0) && (m_st[1] == 0);
        lat_ok = (m_addr[6:4] == 3'd2) || (m_addr[6:4] == 3'd3);
        bl = (m_mode[2:0] < 3'd4) ? (1 << m_mode[2:0]) : 1;
        err = 1'b0;
        if (c == 2) err = (m_st[sel] != 0);
        if (c == 3 || c == 4) err = (m_st[sel] != 1);
        if (c == 7) err = !all_idle || !lat_ok;
        if (c == 8) err = !all_idle;
        for (int b = 0; b < 2; b++) begin
            bit pre = (c == 5) && (ap || sel == b);
            if (m_st[b] == 0) begin
                if (c == 2 && !err && sel == b) begin m_st[b] = 1; m_row[b] = m_addr[10:0]; end
            end else if (m_st[b] == 1) begin
                if (pre) m_st[b] = 0;
                else if ((c == 3 || c == 4) && !err && sel == b && ap) begin m_st[b] = 2; m_cnt[b] = bl; end
            end else begin
                if (pre || m_cnt[b] <= 1) begin m_st[b] = 0; m_cnt[b] = 0; end
                else m_cnt[b] = m_cnt[b] - 1;
            end
        end
        if (c == 7 && !err) m_mode = m_addr;
        e_cmd = 9'd1 << c;
        e_err = err;
        m_pins = {cs_n, ras_n, cas_n, we_n, cke};
        m_addr = addr;
    endtask

    task automatic tick(string req);
        @(negedge clk);
        model_edge();
        chk(req, "cmd_oh", 32'(cmd_oh), 32'(e_cmd));
        chk(req, "proto_err", 32'(proto_err), 32'(e_err));
        chk(req, "bank_open", 32'(bank_open), {30'd0, m_st[1] != 0, m_st[0] != 0});
        chk(req, "bank_row", 32'(bank_row), 32'({m_row[1], m_row[0]}));
        chk(req, "mode_word", 32'(mode_word), 32'(m_mode));
    endtask

    task automatic drive(logic c, logic r, logic ca, logic w, logic k, logic [11:0] a);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; addr = a;
    endtask

    task automatic issue(string req, logic c, logic r, logic ca, logic w, logic k, logic [11:0] a);
        drive(c, r, ca, w, k, a);
        tick(req);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        tick(req);
    endtask

    task automatic idle(int n, string req);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        for (int i = 0; i < n; i++) tick(req);
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cmd_oh", 32'(cmd_oh), 32'd0);
        chk("R1", "proto_err", 32'(proto_err), 32'd0);
        chk("R1", "bank_open", 32'(bank_open), 32'd0);
        chk("R1", "bank_row", 32'(bank_row), 32'd0);
        chk("R1", "mode_word", 32'(mode_word), 32'h020);
        rst_n = 1'b1;

        // R2/R3 sweep over every control code, with clock enable low and high
        for (int k = 0; k < 2; k++) begin
            for (int v = 0; v < 16; v++) begin
                issue("R2", v[3], v[2], v[1], v[0], k[0], 12'((v * 397 + k * 211) & 12'hFFF));
            end
        end
        for (int v = 0; v < 16; v++) begin
            issue("R2", v[3], v[2], v[1], v[0], 1'b1, 12'((v * 1237 + 64) & 12'hFFF));
        end
        idle(10, "R6");
        issue("R7", 0, 0, 1, 0, 1, 12'h400);

        // Directed bank sequences
        issue("R9", 0, 0, 0, 0, 1, 12'h032);          // BL4, latency 3
        issue("R4", 0, 0, 1, 1, 1, 12'h5A5);          // bank0 row 5A5
        issue("R4", 0, 0, 1, 1, 1, 12'h9C3);          // bank1 row 1C3
        issue("R8", 0, 0, 1, 1, 1, 12'h0FF);          // bank0 already open
        issue("R10", 0, 0, 0, 1, 1, 12'h000);         // refresh with banks open
        issue("R9", 0, 0, 0, 0, 1, 12'h023);          // mode set with banks open
        issue("R5", 0, 1, 0, 0, 1, 12'h812);          // write bank1, no auto-precharge
        issue("R12", 0, 1, 1, 0, 1, 12'hFFF);         // burst stop
        issue("R6", 0, 1, 0, 1, 1, 12'h407);          // read bank0 with auto-precharge
        idle(6, "R6");
        issue("R5", 0, 1, 0, 1, 1, 12'h003);          // read closed bank0
        issue("R3", 1, 0, 1, 1, 1, 12'h123);          // chip select high
        issue("R3", 0, 0, 1, 1, 0, 12'h123);          // clock enable low
        issue("R7", 0, 0, 1, 0, 1, 12'h800);          // precharge bank1 only
        issue("R7", 0, 0, 1, 0, 1, 12'h000);          // precharge idle bank0
        issue("R9", 0, 0, 0, 0, 1, 12'h001);          // reserved latency code
        issue("R9", 0, 0, 0, 0, 1, 12'h033);          // BL8, latency 3
        issue("R10", 0, 0, 0, 1, 1, 12'hABC);         // legal refresh
        issue("R4", 0, 0, 1, 1, 1, 12'h07E);
        issue("R4", 0, 0, 1, 1, 1, 12'hF00);
        issue("R6", 0, 1, 0, 0, 1, 12'hC00);          // write bank1 with auto-precharge
        issue("R5", 0, 1, 0, 1, 1, 12'h804);          // read closing bank1
        issue("R8", 0, 0, 1, 1, 1, 12'h811);          // activate closing bank1
        idle(8, "R6");
        issue("R4", 0, 0, 1, 1, 1, 12'h9AA);
        issue("R6", 0, 1, 0, 1, 1, 12'h400);          // read bank0 auto-precharge
        issue("R7", 0, 0, 1, 0, 1, 12'h400);          // precharge all while closing
        issue("R9", 0, 0, 0, 0, 1, 12'h020);          // BL1, latency 2
        issue("R4", 0, 0, 1, 1, 1, 12'h111);
        issue("R6", 0, 1, 0, 0, 1, 12'h400);
        idle(3, "R6");
        issue("R12", 0, 1, 1, 1, 1, 12'h555);
        idle(2, "R11");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule